// File: doc/BRIEF.md
# Power-up reset release timer

This block produces the chip-wide reset. The reset is raised at once by a power-on pulse from the analog detector, or by a low level on the external reset pin. It is lowered only after a fixed number of clock cycles has passed with the selected reset source reading high. The reset source is chosen by a configuration bit. With the bit at 1, the pin serves as the reset input. With the bit at 0, the reset input is tied high inside the block and the pin is handed to the I/O port as a general-purpose input.

A set/clear hold latch works together with a delay counter. Every reset event sets the latch and zeroes the counter. The counter stays idle until the synchronized reset level reads high. When it reaches its terminal count, it clears the latch and then holds at that count until the next reset event. The delay length is a parameter in clock cycles. For example, 18 ms at a 1 MHz clock is 18000 cycles.

Top module: `por_release_timer`

## Requirements
- R1: A high level on `por_pulse` asserts `chip_rst` and zeroes the delay count, so a new full delay is needed after the pulse ends.
- R2: With the effective reset level high, `chip_rst` stays 1 after the first DELAY_CYCLES+1 rising clock edges and reads 0 after edge DELAY_CYCLES+2. That count is two synchronizer edges plus DELAY_CYCLES counting edges.
- R3: While the effective reset level is low, the counter does not advance, however long the low level lasts. The delay is therefore measured from the rise of the reset level, not from power-up.
- R4: A low level on the reset pin while `cfg_pin_rst` is 1 re-asserts `chip_rst` and restarts the full delay. This holds at any point mid-count, including in the cycle where the count would have ended.
- R5: While `cfg_pin_rst` is 0, the pin level has no effect on `chip_rst`. Release after a power-on pulse then follows R2 even when the pin is held low.
- R6: `pin_is_gpio` is 1 exactly when `cfg_pin_rst` is 0.
- R7: Assertion of `chip_rst` is asynchronous: it reads 1 before the next clock edge after a reset source becomes active. Deassertion happens only at a clock edge.
- R8: Once released, `chip_rst` stays 0 and the count saturates at DELAY_CYCLES until the next reset event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| por_pulse | input | 1 | Power-on detector output, active high |
| rst_pin_n | input | 1 | External reset pin, active low |
| cfg_pin_rst | input | 1 | 1: pin is the reset input; 0: reset input tied high, pin is I/O |
| chip_rst | output | 1 | Internal chip reset, active high |
| pin_is_gpio | output | 1 | Routes the pin to the I/O port |

## Verification
The block's terminal count and a new reset event can land in the same cycle. The bench provokes this by pulling the pin low in the half cycle just before the edge that would end the delay. That case is judged correct only if `chip_rst` never drops and a complete new delay follows. Random pin pulses at random count positions cover the wider mid-count restart. Their outcomes are compared against a bench function giving the expected reset level for each edge since release.

// File: rtl/por_rel_pkg.sv
package por_rel_pkg;

    // Width that holds the values 0..n inclusive
    function automatic int cnt_width(input int n);
        int w;
        w = 1;
        while ((1 << w) <= n) begin
            w = w + 1;
        end
        return w;
    endfunction

    // Two-stage synchronizer state
    typedef struct packed {
        logic meta;
        logic stab;
    } sync_st_t;

endpackage

// File: rtl/por_src_sel.sv
module por_src_sel (
    input  logic rst_pin_n,
    input  logic cfg_pin_rst,
    output logic eff_level,
    output logic pin_low_hit,
    output logic pin_gpio
);
    // Pin is honoured only when configured as reset; otherwise tie high
    always_comb begin
        eff_level   = cfg_pin_rst ? rst_pin_n : 1'b1;
        pin_low_hit = cfg_pin_rst & ~rst_pin_n;
        pin_gpio    = ~cfg_pin_rst;
    end
endmodule

// File: rtl/por_sync2.sv
module por_sync2
    import por_rel_pkg::*;
(
    input  logic clk,
    input  logic arst,
    input  logic din,
    output logic dout
);
    sync_st_t st_d, st_q;

    always_comb begin
        st_d.meta = din;
        st_d.stab = st_q.meta;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout = st_q.stab;
endmodule

// File: rtl/por_delay_cnt.sv
module por_delay_cnt #(
    parameter int DELAY_CYCLES = 18000,
    parameter int CW           = por_rel_pkg::cnt_width(DELAY_CYCLES)
) (
    input  logic          clk,
    input  logic          arst,
    input  logic          run,
    output logic [CW-1:0] cnt,
    output logic          hold
);
    localparam logic [CW-1:0] TERM = CW'(DELAY_CYCLES);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          hold;
    } dly_st_t;

    dly_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // Advance only while the level is high and below terminal count
        if (run && (st_q.cnt != TERM)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
        // Latch clears on reaching terminal; never sets again without arst
        if (st_d.cnt == TERM) begin
            st_d.hold = 1'b0;
        end
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            st_q.cnt  <= '0;
            st_q.hold <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt  = st_q.cnt;
    assign hold = st_q.hold;
endmodule

// File: rtl/por_release_timer.sv
module por_release_timer #(
    parameter int DELAY_CYCLES = 18000
) (
    input  logic clk,
    input  logic por_pulse,
    input  logic rst_pin_n,
    input  logic cfg_pin_rst,
    output logic chip_rst,
    output logic pin_is_gpio
);
    localparam int CW = por_rel_pkg::cnt_width(DELAY_CYCLES);

    logic          eff_level;
    logic          pin_low_hit;
    logic          arst;
    logic          sync_lvl;
    logic [CW-1:0] dly_cnt;
    logic          hold;

    por_src_sel u_sel (
        .rst_pin_n   (rst_pin_n),
        .cfg_pin_rst (cfg_pin_rst),
        .eff_level   (eff_level),
        .pin_low_hit (pin_low_hit),
        .pin_gpio    (pin_is_gpio)
    );

    // Any active source clears the whole chain asynchronously
    assign arst = por_pulse | pin_low_hit;

    por_sync2 u_sync (
        .clk  (clk),
        .arst (arst),
        .din  (eff_level),
        .dout (sync_lvl)
    );

    por_delay_cnt #(
        .DELAY_CYCLES (DELAY_CYCLES),
        .CW           (CW)
    ) u_cnt (
        .clk  (clk),
        .arst (arst),
        .run  (sync_lvl),
        .cnt  (dly_cnt),
        .hold (hold)
    );

    assign chip_rst = hold;
endmodule

// File: rtl/por_release_timer_chk.sv
module por_release_timer_chk #(
    parameter int DELAY_CYCLES = 18000,
    parameter int CW           = por_rel_pkg::cnt_width(DELAY_CYCLES)
) (
    input logic          clk,
    input logic          por_pulse,
    input logic          rst_pin_n,
    input logic          cfg_pin_rst,
    input logic          chip_rst,
    input logic          sync_lvl,
    input logic [CW-1:0] dly_cnt
);
    logic src_on;
    assign src_on = por_pulse | (cfg_pin_rst & ~rst_pin_n);

    p_por_hold_r1: assert property (@(posedge clk)
        por_pulse |-> chip_rst)
        else $error("R1 reset not held during power-on pulse");

    p_pin_hold_r4: assert property (@(posedge clk)
        (cfg_pin_rst && !rst_pin_n) |-> chip_rst)
        else $error("R4 reset not held while pin low");

    p_full_delay_r2: assert property (@(posedge clk) disable iff (src_on)
        $fell(chip_rst) |-> (dly_cnt == CW'(DELAY_CYCLES)) && $past(sync_lvl))
        else $error("R2 release before terminal count");

    p_idle_low_r3: assert property (@(posedge clk) disable iff (src_on)
        !sync_lvl |=> (dly_cnt == $past(dly_cnt)))
        else $error("R3 counter moved while level low");

    p_stay_released_r8: assert property (@(posedge clk) disable iff (src_on)
        !chip_rst |=> !chip_rst)
        else $error("R8 reset re-raised without a source");

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (src_on)
        dly_cnt <= CW'(DELAY_CYCLES))
        else $error("R8 count past terminal");
endmodule

bind por_release_timer por_release_timer_chk #(
    .DELAY_CYCLES (DELAY_CYCLES),
    .CW           (CW)
) u_chk (
    .clk         (clk),
    .por_pulse   (por_pulse),
    .rst_pin_n   (rst_pin_n),
    .cfg_pin_rst (cfg_pin_rst),
    .chip_rst    (chip_rst),
    .sync_lvl    (sync_lvl),
    .dly_cnt     (dly_cnt)
);

// File: tb/por_release_timer_bench.sv
module por_release_timer_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DLY        = 20;

    logic clk = 1'b0;
    logic por_pulse;
    logic rst_pin_n;
    logic cfg_pin_rst;
    logic chip_rst;
    logic pin_is_gpio;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    por_release_timer #(.DELAY_CYCLES(DLY)) u_por_release_timer (
        .clk         (clk),
        .por_pulse   (por_pulse),
        .rst_pin_n   (rst_pin_n),
        .cfg_pin_rst (cfg_pin_rst),
        .chip_rst    (chip_rst),
        .pin_is_gpio (pin_is_gpio)
    );

    // Expected reset level k rising edges after the source went inactive
    function automatic logic exp_rst(input int k);
        return (k < DLY + 2);
    endfunction

    task automatic chk(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    // Called right after the source was released at a negedge
    task automatic check_release(input string req);
        for (int k = 1; k <= DLY + 4; k++) begin
            @(negedge clk);
            chk(chip_rst, exp_rst(k), req);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        por_pulse   = 1'b1;
        rst_pin_n   = 1'b1;
        cfg_pin_rst = 1'b1;
        #1;
        chk(chip_rst, 1'b1, "R1 reset state");
        chk(pin_is_gpio, 1'b0, "R6 pin as reset");
        repeat (3) @(negedge clk);
        chk(chip_rst, 1'b1, "R1 held during pulse");
        por_pulse = 1'b0;
        check_release("R2 delay after power-on");

        // R8: stays released and saturated
        repeat (60) @(negedge clk);
        chk(chip_rst, 1'b0, "R8 stays released");

        // R7 async assert, R3 long low hold
        rst_pin_n = 1'b0;
        #1;
        chk(chip_rst, 1'b1, "R7 async assert on pin low");
        repeat (120) @(negedge clk);
        chk(chip_rst, 1'b1, "R3 held during long low");
        rst_pin_n = 1'b1;
        check_release("R3 delay from pin rise");

        // R4: directed terminal-cycle collision, then random mid-count pulses
        for (int i = 0; i < 10; i++) begin
            int pos;
            int wid;
            pos = (i == 0) ? DLY + 1 : int'($urandom % (DLY + 1)) + 1;
            wid = int'($urandom % 3) + 1;
            rst_pin_n = 1'b0;
            @(negedge clk);
            rst_pin_n = 1'b1;
            repeat (pos) @(negedge clk);
            chk(chip_rst, 1'b1, "R4 still counting");
            rst_pin_n = 1'b0;
            #1;
            chk(chip_rst, 1'b1, "R4 mid-count reassert");
            repeat (wid) @(negedge clk);
            rst_pin_n = 1'b1;
            check_release("R4 full restart");
        end

        // R5/R6: pin freed for I/O
        cfg_pin_rst = 1'b1;
        @(negedge clk);
        cfg_pin_rst = 1'b0;
        #1;
        chk(pin_is_gpio, 1'b1, "R6 pin as gpio");
        for (int c = 0; c < 40; c++) begin
            rst_pin_n = logic'($urandom % 2);
            @(negedge clk);
            chk(chip_rst, 1'b0, "R5 pin ignored");
        end
        rst_pin_n = 1'b0;
        por_pulse = 1'b1;
        #1;
        chk(chip_rst, 1'b1, "R7 async assert on power-on");
        repeat (2) @(negedge clk);
        por_pulse = 1'b0;
        check_release("R5 tied-high release with pin low");

        // R1: power-on pulse after release restarts delay
        cfg_pin_rst = 1'b1;
        rst_pin_n   = 1'b1;
        repeat (5) @(negedge clk);
        chk(pin_is_gpio, 1'b0, "R6 back to reset pin");
        por_pulse = 1'b1;
        @(negedge clk);
        por_pulse = 1'b0;
        check_release("R1 power-on restart");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end
endmodule